// File: doc/BRIEF.md
# Pipelined Synchronous SRAM with Byte-Lane Writes

This block is a synthesizable behavioural model of a small synchronous static RAM. Every control, address and write-data input is captured on the rising clock edge. A cycle counts only when all three chip-select inputs agree. A selected cycle is either a write or a read. A write stores some or all of the 9-bit byte lanes, and each lane carries its parity bit as bit 8. A read sends the addressed word through an output register, so the word reaches the data pins one cycle after the address was captured.

The output drivers are modelled as a data vector plus a drive-enable flag, for a pad-level tristate outside the block. The drive enable is the combinational AND of the active-low output-enable pin and a "read result valid" bit in the output stage. As a result, any cycle captured after a read that is not itself a read (a deselect, or a write) releases the bus after the next rising edge. Burst address sequencing is outside this block and comes from a separate sequencer. The reset input is active low and asynchronous, and it is expected to be released in step with the clock. The storage array is not reset.

Top module: `pipe_sram`

## Requirements
- R1: After reset, and before any read has been captured, `dq_oe` is 0.
- R2: A cycle is selected only when `en_a_n`=0, `en_b`=1 and `en_c_n`=0 at the rising edge. With any one of them in the other state, nothing is written and no read result is driven.
- R3: When `wr_all_n`=1 and `lane_gate_n`=0, lane i (bits 9i+8 down to 9i, parity in bit 9i+8) is written if and only if `lane_wr_n[i]`=0. The other lanes keep their contents.
- R4: When `wr_all_n`=0, all four lanes are written, whatever `lane_gate_n` and `lane_wr_n` are.
- R5: When `wr_all_n`=1 and `lane_gate_n`=1, the selected cycle is a read. `lane_wr_n` is then ignored and memory does not change.
- R6: A read captured at edge k drives its word on `dq_out` with `dq_oe`=1 after edge k+1, provided `out_en_n`=0. It is not driven after edge k.
- R7: `out_en_n` acts on `dq_oe` without waiting for a clock edge. Setting it to 1 releases the bus, and clearing it back to 0 drives the bus again in the same cycle.
- R8: When a deselected cycle follows a read, `dq_oe` returns to 0 after the edge that follows the one that drove the read data.
- R9: The bus is never driven for a write cycle. A write captured at edge k leaves `dq_oe`=0 after edge k+1.
- R10: A read of an address captured one edge after a write to that address returns the newly written data.
- R11: Reads captured on consecutive edges appear on consecutive cycles, each address's word exactly one cycle after its capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with the clock |
| en_a_n | input | 1 | Chip select, active low |
| en_b | input | 1 | Chip select, active high |
| en_c_n | input | 1 | Chip select, active low |
| addr | input | AW (6) | Word address |
| wr_all_n | input | 1 | Write all lanes, active low, overrides the lane enables |
| lane_gate_n | input | 1 | Master enable for the per-lane writes, active low |
| lane_wr_n | input | LANES (4) | Per-lane write enables, active low |
| dq_in | input | LANES*LW (36) | Write data, lane i at bits 9i+8 down to 9i |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| dq_out | output | LANES*LW (36) | Read data, zero when not driven |
| dq_oe | output | 1 | Drive enable for the external data pads |

## Verification
The assertions rely on two assumptions about the inputs. The reset is released on a clock edge. The chip-select, write-control and address inputs are stable across each rising edge, so one sampled value per edge describes each cycle. The data check in the checker also assumes that a full-word write immediately followed by a read of the same address is the only traffic to that address in that window. The bench changes all inputs only at falling edges. It reads back only addresses it has written through its own model, and it never toggles `out_en_n` near a rising edge.

// File: rtl/psram_pkg.sv
package psram_pkg;
  // Three-way chip-select qualification shared by the design and its checker.
  function automatic logic chip_selected(input logic a_n, input logic b, input logic c_n);
    return (~a_n) & b & (~c_n);
  endfunction
endpackage

// File: rtl/psram_in_stage.sv
// Input capture: decodes the cycle type and registers address, lane mask and data.
module psram_in_stage #(
  parameter int AW    = 6,
  parameter int LANES = 4,
  parameter int LW    = 9,
  localparam int DW   = LANES * LW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_a_n,
  input  logic             en_b,
  input  logic             en_c_n,
  input  logic [AW-1:0]    addr,
  input  logic             wr_all_n,
  input  logic             lane_gate_n,
  input  logic [LANES-1:0] lane_wr_n,
  input  logic [DW-1:0]    dq_in,
  output logic             sel_q,
  output logic             rd_q,
  output logic [LANES-1:0] mask_q,
  output logic [AW-1:0]    addr_q,
  output logic [DW-1:0]    wdata_q
);
  import psram_pkg::*;

  logic             sel_d;
  logic             rd_d;
  logic [LANES-1:0] mask_d;

  always_comb begin
    sel_d = chip_selected(en_a_n, en_b, en_c_n);
    if (!wr_all_n) begin
      mask_d = '1;
    end else if (!lane_gate_n) begin
      mask_d = ~lane_wr_n;
    end else begin
      mask_d = '0;
    end
    if (!sel_d) begin
      mask_d = '0;
    end
    rd_d = sel_d & wr_all_n & lane_gate_n;
  end

  // Control state: reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= 1'b0;
      rd_q   <= 1'b0;
      mask_q <= '0;
    end else begin
      sel_q  <= sel_d;
      rd_q   <= rd_d;
      mask_q <= mask_d;
    end
  end

  // Address and data: no reset, loaded only on selected cycles.
  always_ff @(posedge clk) begin
    if (sel_d) begin
      addr_q  <= addr;
      wdata_q <= dq_in;
    end
  end
endmodule

// File: rtl/psram_array.sv
// Storage: one memory per byte lane, each with its own write enable.
module psram_array #(
  parameter int AW    = 6,
  parameter int LANES = 4,
  parameter int LW    = 9,
  localparam int DW    = LANES * LW,
  localparam int DEPTH = 1 << AW
) (
  input  logic             clk,
  input  logic             sel_q,
  input  logic [LANES-1:0] mask_q,
  input  logic [AW-1:0]    addr_q,
  input  logic [DW-1:0]    wdata_q,
  output logic [DW-1:0]    rdata
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LW-1:0] mem [DEPTH];
    logic          lane_we;

    assign lane_we = sel_q & mask_q[g];

    always_ff @(posedge clk) begin
      if (lane_we) begin
        mem[addr_q] <= wdata_q[g*LW +: LW];
      end
    end

    assign rdata[g*LW +: LW] = mem[addr_q];
  end
endmodule

// File: rtl/psram_out_stage.sv
// Output register and read-valid flag that decides whether the bus may be driven.
module psram_out_stage #(
  parameter int DW = 36
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_q,
  input  logic [DW-1:0] rdata,
  output logic [DW-1:0] dout_q,
  output logic          vld_q
);
  logic          vld_d;
  logic [DW-1:0] dout_d;

  always_comb begin
    vld_d  = rd_q;
    dout_d = rd_q ? rdata : dout_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rd_q) begin
      dout_q <= dout_d;
    end
  end
endmodule

// File: rtl/pipe_sram.sv
// Top: input capture -> lane memories -> output register -> gated drive.
module pipe_sram #(
  parameter int AW    = 6,
  parameter int LANES = 4,
  parameter int LW    = 9,
  localparam int DW   = LANES * LW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_a_n,
  input  logic             en_b,
  input  logic             en_c_n,
  input  logic [AW-1:0]    addr,
  input  logic             wr_all_n,
  input  logic             lane_gate_n,
  input  logic [LANES-1:0] lane_wr_n,
  input  logic [DW-1:0]    dq_in,
  input  logic             out_en_n,
  output logic [DW-1:0]    dq_out,
  output logic             dq_oe
);
  logic             sel_q;
  logic             rd_q;
  logic [LANES-1:0] mask_q;
  logic [AW-1:0]    addr_q;
  logic [DW-1:0]    wdata_q;
  logic [DW-1:0]    rdata;
  logic [DW-1:0]    dout_q;
  logic             vld_q;

  psram_in_stage #(.AW(AW), .LANES(LANES), .LW(LW)) u_in (
    .clk(clk), .rst_n(rst_n),
    .en_a_n(en_a_n), .en_b(en_b), .en_c_n(en_c_n),
    .addr(addr), .wr_all_n(wr_all_n), .lane_gate_n(lane_gate_n),
    .lane_wr_n(lane_wr_n), .dq_in(dq_in),
    .sel_q(sel_q), .rd_q(rd_q), .mask_q(mask_q),
    .addr_q(addr_q), .wdata_q(wdata_q)
  );

  psram_array #(.AW(AW), .LANES(LANES), .LW(LW)) u_mem (
    .clk(clk), .sel_q(sel_q), .mask_q(mask_q),
    .addr_q(addr_q), .wdata_q(wdata_q), .rdata(rdata)
  );

  psram_out_stage #(.DW(DW)) u_out (
    .clk(clk), .rst_n(rst_n), .rd_q(rd_q), .rdata(rdata),
    .dout_q(dout_q), .vld_q(vld_q)
  );

  // Asynchronous output enable gates the registered drive request.
  assign dq_oe  = ~out_en_n & vld_q;
  assign dq_out = dq_oe ? dout_q : '0;
endmodule

// File: rtl/psram_chk.sv
// Port-level properties, attached to every pipe_sram instance.
module psram_chk #(
  parameter int AW = 6,
  parameter int DW = 36
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en_a_n,
  input logic          en_b,
  input logic          en_c_n,
  input logic [AW-1:0] addr,
  input logic          wr_all_n,
  input logic          lane_gate_n,
  input logic [DW-1:0] dq_in,
  input logic          out_en_n,
  input logic [DW-1:0] dq_out,
  input logic          dq_oe
);
  import psram_pkg::*;

  logic       sel_now;
  logic       rd_now;
  logic       wr_now;
  logic       full_wr_now;
  logic [1:0] age_q;

  assign sel_now     = chip_selected(en_a_n, en_b, en_c_n);
  assign rd_now      = sel_now & wr_all_n & lane_gate_n;
  assign wr_now      = sel_now & ~(wr_all_n & lane_gate_n);
  assign full_wr_now = sel_now & ~wr_all_n;

  // Edges since reset, saturating, so no $past reaches before reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age_q <= '0;
    end else if (age_q != 2'd3) begin
      age_q <= age_q + 2'd1;
    end
  end

  // R2 R8
  desel_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_now |=> ##1 !dq_oe);

  // R9
  write_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_now |=> ##1 !dq_oe);

  // R6
  read_drives_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_now |=> ##1 (out_en_n || dq_oe));

  // R10
  raw_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd3 && rd_now && $past(full_wr_now) && addr == $past(addr))
    |=> ##1 (out_en_n || (dq_oe && dq_out == $past(dq_in, 3))));
endmodule

bind pipe_sram psram_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .en_a_n(en_a_n), .en_b(en_b), .en_c_n(en_c_n),
  .addr(addr), .wr_all_n(wr_all_n), .lane_gate_n(lane_gate_n),
  .dq_in(dq_in), .out_en_n(out_en_n), .dq_out(dq_out), .dq_oe(dq_oe)
);

// File: tb/sim_pipe_sram.sv
`timescale 1ns/1ps
module sim_pipe_sram;
  localparam int AW = 6;
  localparam int LANES = 4;
  localparam int LW = 9;
  localparam int DW = LANES * LW;

  logic clk = 1'b0;
  logic rst_n;
  logic en_a_n, en_b, en_c_n;
  logic [AW-1:0] addr;
  logic wr_all_n, lane_gate_n;
  logic [LANES-1:0] lane_wr_n;
  logic [DW-1:0] dq_in;
  logic out_en_n;
  logic [DW-1:0] dq_out;
  logic dq_oe;

  logic [DW-1:0] model [1 << AW];
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pipe_sram #(.AW(AW), .LANES(LANES), .LW(LW)) u0 (
    .clk(clk), .rst_n(rst_n), .en_a_n(en_a_n), .en_b(en_b), .en_c_n(en_c_n),
    .addr(addr), .wr_all_n(wr_all_n), .lane_gate_n(lane_gate_n),
    .lane_wr_n(lane_wr_n), .dq_in(dq_in), .out_en_n(out_en_n),
    .dq_out(dq_out), .dq_oe(dq_oe)
  );

  task automatic check(input bit ok, input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Drive one cycle's inputs; s = {en_a_n, en_b, en_c_n}.
  task automatic drv(input logic [2:0] s, input logic [AW-1:0] a, input logic gw,
                     input logic gate, input logic [LANES-1:0] ln, input logic [DW-1:0] d);
    {en_a_n, en_b, en_c_n} = s;
    addr = a; wr_all_n = gw; lane_gate_n = gate; lane_wr_n = ln; dq_in = d;
    // bench model of the write rules (R2 R3 R4)
    if (s == 3'b010) begin
      for (int i = 0; i < LANES; i++) begin
        if (!gw || (!gate && !ln[i])) model[a][i*LW +: LW] = d[i*LW +: LW];
      end
    end
  endtask

  task automatic idle();
    drv(3'b101, '0, 1'b1, 1'b1, '1, '0);
  endtask

  task automatic wr_full(input logic [AW-1:0] a, input logic [DW-1:0] d);
    drv(3'b010, a, 1'b0, 1'b1, '1, d); step(); idle(); step();
  endtask

  // Read and check: data expected after the second edge.
  task automatic rd_check(input logic [AW-1:0] a, input string req);
    drv(3'b010, a, 1'b1, 1'b1, '1, '0); step(); idle(); step();
    check(dq_oe === 1'b1 && dq_out === model[a], req, dq_out, model[a]);
    step();
  endtask

  task automatic t_reset();
    check(dq_oe === 1'b0, "R1 reset", {35'b0, dq_oe}, '0);
  endtask

  task automatic t_global();
    drv(3'b010, 6'd5, 1'b0, 1'b1, 4'b1111, 36'h9_1234_5678); step(); idle(); step();
    rd_check(6'd5, "R4 global write with lane enables high");
    drv(3'b010, 6'd6, 1'b0, 1'b0, 4'b1010, 36'hF_0F0F_0F0F); step(); idle(); step();
    rd_check(6'd6, "R4 global write overrides lane mask");
  endtask

  task automatic t_lanes();
    logic [DW-1:0] exp;
    wr_full(6'd7, 36'h0_0000_0000);
    drv(3'b010, 6'd7, 1'b1, 1'b0, 4'b1010, 36'hF_FFFF_FFFF); step(); idle(); step();
    exp = {9'h000, 9'h1FF, 9'h000, 9'h1FF};
    check(model[7] === exp, "R3 bench model", model[7], exp);
    rd_check(6'd7, "R3 lanes 0 and 2 with parity");
    drv(3'b010, 6'd7, 1'b1, 1'b0, 4'b0111, 36'h8_0000_0000); step(); idle(); step();
    rd_check(6'd7, "R3 only parity bit of lane 3");
  endtask

  task automatic t_read_ignores();
    drv(3'b010, 6'd5, 1'b1, 1'b1, 4'b0000, 36'h0_DEAD_BEEF); step(); idle(); step();
    rd_check(6'd5, "R5 lane enables ignored on read");
  endtask

  task automatic t_select();
    logic [2:0] bad [3] = '{3'b110, 3'b000, 3'b011};
    for (int k = 0; k < 3; k++) begin
      drv(bad[k], 6'd5, 1'b0, 1'b0, 4'b0000, 36'h0_5555_AAAA); step();
      drv(bad[k], 6'd5, 1'b1, 1'b1, 4'b1111, '0); step();
      check(dq_oe === 1'b0, "R2 unselected read not driven", {35'b0, dq_oe}, '0);
      idle(); step();
      rd_check(6'd5, "R2 unselected write ignored");
    end
  endtask

  task automatic t_latency();
    drv(3'b010, 6'd6, 1'b1, 1'b1, '1, '0); step();
    check(dq_oe === 1'b0, "R6 not driven after first edge", {35'b0, dq_oe}, '0);
    idle(); step();
    check(dq_oe === 1'b1 && dq_out === model[6], "R6 driven after second edge", dq_out, model[6]);
    out_en_n = 1'b1; #1;
    check(dq_oe === 1'b0, "R7 output enable released", {35'b0, dq_oe}, '0);
    out_en_n = 1'b0; #0.5;
    check(dq_oe === 1'b1 && dq_out === model[6], "R7 output enable restored", dq_out, model[6]);
    step();
    check(dq_oe === 1'b0, "R8 deselect releases bus", {35'b0, dq_oe}, '0);
  endtask

  task automatic t_write_no_drive();
    drv(3'b010, 6'd5, 1'b1, 1'b1, '1, '0); step();
    drv(3'b010, 6'd9, 1'b0, 1'b1, '1, 36'h3_3333_3333); step();
    check(dq_oe === 1'b1 && dq_out === model[5], "R9 prior read driven", dq_out, model[5]);
    idle(); step();
    check(dq_oe === 1'b0, "R9 write cycle not driven", {35'b0, dq_oe}, '0);
  endtask

  task automatic t_raw();
    drv(3'b010, 6'd12, 1'b0, 1'b1, '1, 36'hA_BCDE_F012); step();
    drv(3'b010, 6'd12, 1'b1, 1'b1, '1, '0); step(); idle(); step();
    check(dq_oe === 1'b1 && dq_out === 36'hA_BCDE_F012, "R10 read after write", dq_out, 36'hA_BCDE_F012);
    step();
  endtask

  task automatic t_stream();
    drv(3'b010, 6'd5, 1'b1, 1'b1, '1, '0); step();
    drv(3'b010, 6'd6, 1'b1, 1'b1, '1, '0); step();
    check(dq_oe === 1'b1 && dq_out === model[5], "R11 stream word 0", dq_out, model[5]);
    drv(3'b010, 6'd7, 1'b1, 1'b1, '1, '0); step();
    check(dq_oe === 1'b1 && dq_out === model[6], "R11 stream word 1", dq_out, model[6]);
    idle(); step();
    check(dq_oe === 1'b1 && dq_out === model[7], "R11 stream word 2", dq_out, model[7]);
    step();
    check(dq_oe === 1'b0, "R11 stream end", {35'b0, dq_oe}, '0);
  endtask

  initial begin
    rst_n = 1'b0; out_en_n = 1'b0;
    idle();
    repeat (3) @(negedge clk);
    t_reset();
    @(posedge clk); rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_global();
    t_lanes();
    t_read_ignores();
    t_select();
    t_latency();
    t_write_no_drive();
    t_raw();
    t_stream();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule